// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer/Event Counter

This block is a 16-bit up-counter that reloads itself from a preload register. A small 8-bit register port reaches it through three addresses: a control byte, a low byte and a high byte. The counter steps on one of two sources. The first is a tick taken from the system clock through a divide-by-`DIV` prescaler (timer mode). The second is a chosen edge of an external event pin, which is brought into the clock domain by a synchronizer (event mode). When the counter steps past all ones it reloads from the preload value, keeps counting, and raises a one-cycle interrupt pulse.

The preload is always written as a pair. A byte written to the low address waits in a buffer. A write to the high address commits the high byte and the buffered low byte together. While the counter is stopped, that commit also loads the counter. While it runs, the new value waits in the preload register until the next overflow. Reads are made coherent in the same way. Reading the high byte returns the live high byte and captures the live low byte into a read buffer. A later read of the low address returns that captured byte.

A small state machine holds the counting state. It has three states: `ST_IDLE` (not counting), `ST_TIMER` (counting prescaler ticks) and `ST_EVENT` (counting pin edges). On every clock it moves to the state that the control byte held before that edge. The transitions are start_timer (IDLE→TIMER), start_event (IDLE→EVENT), halt (TIMER/EVENT→IDLE) and switch (TIMER↔EVENT). A control write therefore takes effect one cycle after it is captured.

Top module: `pair_timer`

## Requirements
- R1: In timer mode the counter steps by exactly one every `DIV` system clock cycles (default 4). The prescaler is cleared while the timer state is not active, and two internal ticks are never back to back when `DIV` > 1.
- R2: In event mode the counter steps once per qualifying edge of `evt_pin`, seen after a two-flop synchronizer. Control bit 3 = 0 counts rising edges and = 1 counts falling edges.
- R3: A step taken while the counter holds 16'hFFFF loads the preload value into the counter. `ovf_irq` is then high for exactly one cycle, the cycle after that step, and counting goes on from the preload value.
- R4: While the state is `ST_IDLE`, a write to address 2 sets both the preload and the counter to {wdata, low buffer}.
- R5: While counting, a write to address 2 updates only the preload. The counter picks up the new value at the next overflow.
- R6: A write to address 1 stores the byte in the low buffer only. The counter and the preload are unchanged, and a later write to address 1 replaces the buffered byte.
- R7: Reading address 2 returns the live counter high byte and captures the live low byte into the read buffer. Reading address 1 returns the read buffer, not the live low byte.
- R8: With a preload of zero, the interval between two overflows is 65536 steps.
- R9: The control byte sits at address 0: bit 0 = run, bits 2:1 = mode, bit 3 = edge select, and it reads back as written. Mode 01 is event mode and mode 10 is timer mode. Mode 00, mode 11, or run = 0 leave the counter stopped and frozen.
- R10: Reset clears the counter, the preload, both byte buffers and the control byte, and holds `ovf_irq` low. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 low byte, 2 high byte |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on `bus_addr` |
| evt_pin | input | 1 | Asynchronous external event input |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench builds the block with `DIV` = 2 instead of the default 4. This keeps the prescaler counting path in use rather than the pass-through variant. It also makes a full zero-preload period of 65536 steps short enough to measure from overflow to overflow. A behavioural model in the bench follows the block cycle by cycle, including the one-cycle state latency and the synchronizer delay. The model's overflow pulse is compared on every clock. Register reads are compared both with the model and with values worked out by hand for the deferred preload, the coherent pair read and the edge-select cases.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMER = 2'd1,
        ST_EVENT = 2'd2
    } pt_state_e;

    // control byte layout, LSB first: run, mode[1:0], edge select
    typedef struct packed {
        logic       edge_fall;
        logic [1:0] mode;
        logic       run;
    } pt_ctrl_t;

    localparam logic [1:0] MODE_EVENT = 2'b01;
    localparam logic [1:0] MODE_TIMER = 2'b10;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

endpackage

// File: rtl/pt_ctrl_fsm.sv
module pt_ctrl_fsm
    import pt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [3:0] ctrl_d,
    output pt_ctrl_t   ctrl_q,
    output pt_state_e  state_q,
    output logic       timer_on,
    output logic       event_on,
    output logic       stopped
);

    pt_state_e state_d;
    pt_state_e wanted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= pt_ctrl_t'(ctrl_d);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        wanted = ST_IDLE;
        if (ctrl_q.run) begin
            unique case (ctrl_q.mode)
                MODE_EVENT: wanted = ST_EVENT;
                MODE_TIMER: wanted = ST_TIMER;
                default:    wanted = ST_IDLE;
            endcase
        end
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wanted != ST_IDLE) state_d = wanted;   // start_timer / start_event
            ST_TIMER: if (wanted != ST_TIMER) state_d = wanted;  // halt / switch
            ST_EVENT: if (wanted != ST_EVENT) state_d = wanted;  // halt / switch
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        timer_on = 1'b0;
        event_on = 1'b0;
        stopped  = 1'b0;
        unique case (state_q)
            ST_TIMER: timer_on = 1'b1;
            ST_EVENT: event_on = 1'b1;
            default:  stopped  = 1'b1;
        endcase
    end

    // R9: with run clear the block is idle on the next cycle
    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run) |=> (state_q == ST_IDLE));

    // R9: reserved and unused modes never start counting
    assert_reserved_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == 2'b11 || ctrl_q.mode == 2'b00) |=> stopped);

endmodule

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timer_on,
    input  logic event_on,
    input  logic edge_fall,
    input  logic ext_pin,
    output logic tick
);

    localparam int SYNC_N = 3;   // two synchronizer flops plus one history flop

    logic [SYNC_N-1:0] sync_q;
    logic              tick_int;
    logic              tick_evt;
    logic              rise_seen;
    logic              fall_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
        end
    end

    assign rise_seen = sync_q[1] & ~sync_q[2];
    assign fall_seen = ~sync_q[1] & sync_q[2];
    assign tick_evt  = event_on & (edge_fall ? fall_seen : rise_seen);

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick_int = timer_on;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (!timer_on || pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end

            assign tick_int = timer_on && (pre_q == LAST);

            // R1: internal ticks are spaced by the divider
            assert_prescale_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_int |=> !tick_int);
        end
    endgenerate

    assign tick = tick_int | tick_evt;

    // R2: edge ticks only in event mode, internal ticks only in timer mode
    assert_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (timer_on || event_on));

endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic                hi_rd,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                tick,
    input  logic                stopped,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0]   rd_buf_q,
    output logic                ovf_q
);

    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  preload_q;
    logic [DATA_W-1:0] lo_buf_q;
    logic [CNT_W-1:0]  pair_word;
    logic              at_max;

    assign pair_word = {wdata, lo_buf_q};
    assign at_max    = (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_buf_q <= '0;
        end else if (lo_we) begin
            lo_buf_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (hi_we) begin
            preload_q <= pair_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hi_we && stopped) begin
            cnt_q <= pair_word;
        end else if (tick) begin
            cnt_q <= at_max ? preload_q : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= tick && at_max;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_buf_q <= '0;
        end else if (hi_rd) begin
            rd_buf_q <= cnt_q[DATA_W-1:0];
        end
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_max) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == $past(preload_q)));

    assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && hi_we) |=> (cnt_q == {$past(wdata), $past(lo_buf_q)}));

    assert_deferred_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && hi_we && !tick) |=> (cnt_q == $past(cnt_q)));

    assert_lo_buffer_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> (preload_q == $past(preload_q)));

endmodule

// File: rtl/pair_timer.sv
module pair_timer
    import pt_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_pin,
    output logic              ovf_irq
);

    localparam int CNT_W = 2 * DATA_W;

    pt_ctrl_t          ctrl;
    pt_state_e         state;
    logic              timer_on;
    logic              event_on;
    logic              stopped;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rd_buf;

    pt_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (bus_we && bus_addr == ADDR_CTRL),
        .ctrl_d   (bus_wdata[3:0]),
        .ctrl_q   (ctrl),
        .state_q  (state),
        .timer_on (timer_on),
        .event_on (event_on),
        .stopped  (stopped)
    );

    pt_tick_gen #(.DIV(DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_on  (timer_on),
        .event_on  (event_on),
        .edge_fall (ctrl.edge_fall),
        .ext_pin   (evt_pin),
        .tick      (tick)
    );

    pt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (bus_we && bus_addr == ADDR_LO),
        .hi_we    (bus_we && bus_addr == ADDR_HI),
        .hi_rd    (bus_re && bus_addr == ADDR_HI),
        .wdata    (bus_wdata),
        .tick     (tick),
        .stopped  (stopped),
        .cnt_q    (cnt),
        .rd_buf_q (rd_buf),
        .ovf_q    (ovf_irq)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {{(DATA_W-4){1'b0}}, ctrl};
            ADDR_LO:   bus_rdata = rd_buf;
            ADDR_HI:   bus_rdata = cnt[CNT_W-1:DATA_W];
            default:   bus_rdata = '0;
        endcase
    end

    // R3: overflow pulse lasts one cycle unless a second overflow step follows at once
    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !tick) |=> !ovf_irq);

    // R9: a stopped counter does not move except by a direct load
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !(bus_we && bus_addr == ADDR_HI)) |=> (cnt == $past(cnt)));

endmodule

// File: tb/tb_pair_timer.sv
module tb_pair_timer;

    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       evt_pin = 1'b0;
    logic       ovf_irq;

    int checks = 0;
    int fails = 0;
    longint cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    pair_timer #(.DIV(DIV), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pin(evt_pin), .ovf_irq(ovf_irq)
    );

    // behavioural reference model
    logic [3:0]  m_ctrl;
    int          m_mode_now;  // 0 idle, 1 timer, 2 event
    int          m_div_ct;
    logic        m_p1, m_p2, m_p3;
    logic [15:0] m_cnt, m_pl, m_next;
    logic [7:0]  m_lo, m_rb;
    logic        m_ovf, m_step, m_edge;

    always @(posedge clk or negedge rst_n) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_ctrl = 0; m_mode_now = 0; m_div_ct = 0;
            m_p1 = 0; m_p2 = 0; m_p3 = 0;
            m_cnt = 0; m_pl = 0; m_lo = 0; m_rb = 0; m_ovf = 0;
        end else begin
            m_edge = m_ctrl[3] ? (m_p3 && !m_p2) : (m_p2 && !m_p3);
            m_step = (m_mode_now == 1 && m_div_ct == DIV - 1) || (m_mode_now == 2 && m_edge);
            m_next = m_cnt;
            if (bus_we && bus_addr == 2 && m_mode_now == 0) m_next = {bus_wdata, m_lo};
            else if (m_step) m_next = (m_cnt == 16'hFFFF) ? m_pl : m_cnt + 16'd1;
            m_ovf = m_step && (m_cnt == 16'hFFFF);
            if (bus_re && bus_addr == 2) m_rb = m_cnt[7:0];
            if (bus_we && bus_addr == 2) m_pl = {bus_wdata, m_lo};
            if (bus_we && bus_addr == 1) m_lo = bus_wdata;
            m_div_ct = (m_mode_now == 1) ? ((m_div_ct == DIV - 1) ? 0 : m_div_ct + 1) : 0;
            if (!m_ctrl[0]) m_mode_now = 0;
            else if (m_ctrl[2:1] == 2'b10) m_mode_now = 1;
            else if (m_ctrl[2:1] == 2'b01) m_mode_now = 2;
            else m_mode_now = 0;
            if (bus_we && bus_addr == 0) m_ctrl = bus_wdata[3:0];
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = evt_pin;
            m_cnt = m_next;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // overflow pulse compared on every clock (R3)
    always @(negedge clk) begin
        if (rst_n && cyc > 2) chk(ovf_irq == m_ovf, "R3 ovf_irq vs model", ovf_irq, m_ovf);
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_pair(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd2, h);
        rd(2'd1, l);
        v = {h, l};
    endtask

    task automatic pulse_evt();
        @(negedge clk); evt_pin = 1'b1;
        repeat (4) @(negedge clk);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ovf();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (ovf_irq) break;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] p1, p2;
        longint      t1, t2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(2'd0, v); chk(v == 8'h00, "R10 ctrl after reset", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R10 counter high after reset", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R10 read buffer after reset", v, 0);
        rd(2'd3, v); chk(v == 8'h00, "R10 address 3 reads zero", v, 0);
        chk(ovf_irq == 1'b0, "R10 ovf low after reset", ovf_irq, 0);

        // R6 low write lands in buffer only
        wr(2'd1, 8'h12);
        rd_pair(p1); chk(p1 == 16'h0000, "R6 counter untouched by low write", p1, 16'h0000);
        wr(2'd1, 8'hF0);
        // R4 stopped high write loads counter with latest buffered low byte
        wr(2'd2, 8'hFF);
        rd_pair(p1); chk(p1 == 16'hFFF0, "R4 direct load when stopped", p1, 16'hFFF0);

        // R9 control readback and timer start
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk(v == 8'h05, "R9 control readback", v, 8'h05);
        // R5 preload written while running is deferred
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h80);
        rd(2'd2, v); chk(v == 8'hFF, "R5 counter keeps counting toward max", v, 8'hFF);
        chk(v == m_cnt[15:8], "R1 counter high vs model", v, m_cnt[15:8]);
        wait_ovf();
        chk(ovf_irq == 1'b1, "R3 overflow pulse seen", ovf_irq, 1);
        rd(2'd2, v); chk(v == 8'h80, "R5 deferred preload taken at overflow", v, 8'h80);

        // R7 coherent pair read
        rd(2'd2, v);
        p2[7:0] = m_rb;
        repeat (12) @(negedge clk);
        rd(2'd1, v);
        chk(v == p2[7:0], "R7 low read returns latched byte", v, p2[7:0]);
        chk(m_cnt[7:0] != v, "R7 live low byte moved on", m_cnt[7:0], v);

        // R1 step rate: DIV cycles per step
        rd_pair(p1);
        repeat (20) @(negedge clk);
        rd_pair(p2);
        chk(p2 - p1 == 16'd12, "R1 prescaled step count over 24 cycles", p2 - p1, 12);

        // R9 run clear freezes
        wr(2'd0, 8'h04);
        rd_pair(p1);
        repeat (20) @(negedge clk);
        rd_pair(p2);
        chk(p1 == p2, "R9 frozen with run clear", p2, p1);
        // R9 reserved mode 11 with run set stays stopped
        wr(2'd0, 8'h07);
        repeat (20) @(negedge clk);
        rd_pair(p2);
        chk(p1 == p2, "R9 reserved mode frozen", p2, p1);

        // R2 event mode, rising edges
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFD);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h03);
        repeat (3) @(negedge clk);
        pulse_evt();
        rd_pair(p1); chk(p1 == 16'hFFFE, "R2 one rising edge counted", p1, 16'hFFFE);
        pulse_evt();
        pulse_evt();
        rd_pair(p1); chk(p1 == 16'hFFFD, "R3 event overflow reloads preload", p1, 16'hFFFD);
        // R2 falling edge select
        wr(2'd0, 8'h0B);
        repeat (3) @(negedge clk);
        @(negedge clk); evt_pin = 1'b1;
        repeat (5) @(negedge clk);
        rd_pair(p1); chk(p1 == 16'hFFFD, "R2 rising edge ignored in falling mode", p1, 16'hFFFD);
        evt_pin = 1'b0;
        repeat (5) @(negedge clk);
        rd_pair(p1); chk(p1 == 16'hFFFE, "R2 falling edge counted", p1, 16'hFFFE);
        chk(p1 == m_cnt, "R2 counter vs model", p1, m_cnt);

        // R8 full period with zero preload
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wait_ovf();
        t1 = cyc;
        rd(2'd2, v); chk(v == 8'h00, "R8 counter restarts from zero", v, 0);
        for (int i = 0; i < 140000; i++) begin
            @(negedge clk);
            if (ovf_irq) break;
        end
        t2 = cyc;
        chk(t2 - t1 == 65536 * DIV, "R8 full period length in cycles", t2 - t1, 65536 * DIV);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule